// File: doc/BRIEF.md
# Nibble Parity Byte Encoder

This block takes a stream of data bytes and turns each one into two protected bytes, ready to be written into a one-time-programmable fuse array. Each 4-bit half of the input is widened to 8 bits. The four data bits are kept as they are, and four pairwise parity bits are placed above them. The half in bits [3:0] of the input always leaves first and the half in bits [7:4] follows it. Each emitted byte carries a storage address, so the pair lands at two consecutive locations.

Both sides use a valid/ready handshake. A one-byte holding register sits between them. A new input byte is taken only when the holding register is empty, or in the same cycle in which the second encoded byte of the held input is accepted downstream. A sustained stream therefore moves at one input byte every two cycles. An address counter is loaded from a base value by a one-cycle load strobe. It then steps by one on every accepted output byte.

Top module: `nibble_ecc_stream`

## Requirements
- R1: Bits [3:0] of every emitted byte equal the data nibble it encodes, unchanged.
- R2: Bit 4 of an emitted byte is the XOR of its bits 0 and 1, and bit 5 is the XOR of its bits 2 and 3.
- R3: Bit 6 of an emitted byte is the XOR of its bits 0 and 2, and bit 7 is the XOR of its bits 1 and 3.
- R4: For each accepted input byte, the encoding of input bits [3:0] is emitted first and the encoding of input bits [7:4] second. Byte order is the order of input acceptance.
- R5: in_ready is low from the cycle after an input byte is accepted until its first encoded byte has been taken. While the second encoded byte is presented, in_ready equals out_ready.
- R6: While out_valid is high and out_ready is low, the next cycle still has out_valid high, with out_data and out_addr unchanged (when base_load is low).
- R7: A base_load pulse sets out_addr to base_addr on the next cycle. Each output handshake (out_valid and out_ready high) without base_load raises out_addr by one, modulo 2^AW.
- R8: After reset, out_valid is low, in_ready is high and out_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load the address counter from base_addr |
| base_addr | input | AW | Base storage address |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Input byte is taken this cycle when in_valid is high |
| in_data | input | 8 | Input data byte |
| out_valid | output | 1 | Encoded byte is presented |
| out_ready | input | 1 | Downstream accepts the presented byte |
| out_data | output | 8 | Encoded byte: nibble in [3:0], parity in [7:4] |
| out_addr | output | AW | Storage address of the presented byte |

## Verification
The parity and handshake assertions place no demands on the inputs. The stall and address-step properties leave out cycles in which base_load is high, because a load may legally move the address during a stall. The bench pulses base_load only while the block is idle. It holds in_data steady while a byte waits for acceptance, and it sweeps all 256 byte values, once with full throughput and once under pseudo-random gaps on both sides. The base address is chosen so that the counter wraps during the sweep.

// File: rtl/nibble_ecc_pkg.sv
package nibble_ecc_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/nibble_ecc_enc.sv
module nibble_ecc_enc
  import nibble_ecc_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [BYTE_W-1:0] code
);

  logic [NIB_W-1:0] par;

  always_comb begin
    par[0] = nib[0] ^ nib[1];
    par[1] = nib[2] ^ nib[3];
    par[2] = nib[0] ^ nib[2];
    par[3] = nib[1] ^ nib[3];
    code   = {par, nib};
  end

endmodule

// File: rtl/nibble_ecc_seq.sv
module nibble_ecc_seq
  import nibble_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  cur_nib,
  output logic              out_fire
);

  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              in_fire;

  always_comb begin
    out_valid = (state_q != SEQ_IDLE);
    out_fire  = out_valid && out_ready;
    in_ready  = (state_q == SEQ_IDLE) || ((state_q == SEQ_HI) && out_ready);
    in_fire   = in_valid && in_ready;
    cur_nib   = (state_q == SEQ_HI) ? hold_q[BYTE_W-1:NIB_W] : hold_q[NIB_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    hold_en = in_fire;
    hold_d  = in_data;
    unique case (state_q)
      SEQ_IDLE: if (in_fire) state_d = SEQ_LO;
      SEQ_LO:   if (out_fire) state_d = SEQ_HI;
      SEQ_HI:   if (out_fire) state_d = in_fire ? SEQ_LO : SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/nibble_ecc_addr.sv
module nibble_ecc_addr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || step;
    cnt_d  = load ? base : cnt_q + {{(AW-1){1'b0}}, 1'b1};
    addr   = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nibble_ecc_stream.sv
module nibble_ecc_stream
  import nibble_ecc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_load,
  input  logic [AW-1:0]     base_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [AW-1:0]     out_addr
);

  logic [NIB_W-1:0] cur_nib;
  logic             out_fire;

  nibble_ecc_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .cur_nib   (cur_nib),
    .out_fire  (out_fire)
  );

  nibble_ecc_enc i_enc (
    .nib  (cur_nib),
    .code (out_data)
  );

  nibble_ecc_addr #(.AW(AW)) i_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (base_load),
    .base  (base_addr),
    .step  (out_fire),
    .addr  (out_addr)
  );

endmodule

// File: rtl/nibble_ecc_stream_chk.sv
module nibble_ecc_stream_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          base_load,
  input logic [AW-1:0] base_addr,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [AW-1:0] out_addr
);

  // R2
  par_low_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[4] == (out_data[0] ^ out_data[1])) &&
                  (out_data[5] == (out_data[2] ^ out_data[3])));

  // R3
  par_cross_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[6] == (out_data[0] ^ out_data[2])) &&
                  (out_data[7] == (out_data[1] ^ out_data[3])));

  // R4
  second_byte_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_ready) |=> out_valid);

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !base_load) |=>
      (out_valid && $stable(out_data) && $stable(out_addr)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !base_load) |=> (out_addr == $past(out_addr) + 1'b1));

  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |=> (out_addr == $past(base_addr)));

endmodule

bind nibble_ecc_stream nibble_ecc_stream_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_nibble_ecc_stream.sv
module test_nibble_ecc_stream;

  localparam int AW = 10;

  logic          clk;
  logic          rst_n;
  logic          base_load;
  logic [AW-1:0] base_addr;
  logic          in_valid;
  logic          in_ready;
  logic [7:0]    in_data;
  logic          out_valid;
  logic          out_ready;
  logic [7:0]    out_data;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] cur_base = '0;

  nibble_ecc_stream #(.AW(AW)) i_nibble_ecc_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_load (base_load),
    .base_addr (base_addr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] expect_code(input logic [3:0] n);
    logic [7:0] c;
    c[3:0] = n;
    c[4] = n[0] ^ n[1];
    c[5] = n[2] ^ n[3];
    c[6] = n[0] ^ n[2];
    c[7] = n[1] ^ n[3];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_base(input logic [AW-1:0] b);
    @(negedge clk);
    base_load = 1'b1;
    base_addr = b;
    @(negedge clk);
    base_load = 1'b0;
    cur_base  = b;
    #1;
    check("R7 base load", 32'(out_addr), 32'(b));
  endtask

  task automatic run_pass(input int nbytes, input bit gaps);
    int in_idx  = 0;
    int out_idx = 0;
    bit prev_stall = 0;
    logic [7:0]    prev_data = '0;
    logic [AW-1:0] prev_addr = '0;
    while (out_idx < 2 * nbytes) begin
      @(negedge clk);
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = gaps ? (lfsr[0] | lfsr[3]) : 1'b1;
      in_valid  = (in_idx < nbytes) && (gaps ? (lfsr[1] | lfsr[5]) : 1'b1);
      in_data   = in_idx[7:0];
      #1;
      if (prev_stall) begin
        check("R6 valid held", 32'(out_valid), 32'd1);
        check("R6 data held", 32'(out_data), 32'(prev_data));
        check("R6 addr held", 32'(out_addr), 32'(prev_addr));
      end
      if (out_valid) begin
        logic [7:0] b;
        logic [3:0] n;
        logic [7:0] e;
        b = 8'(out_idx / 2);
        n = (out_idx % 2 == 1) ? b[7:4] : b[3:0];
        e = expect_code(n);
        check("R1 R4 data nibble", 32'(out_data[3:0]), 32'(e[3:0]));
        check("R2 parity 5:4", 32'(out_data[5:4]), 32'(e[5:4]));
        check("R3 parity 7:6", 32'(out_data[7:6]), 32'(e[7:6]));
        check("R7 address", 32'(out_addr), 32'(AW'(cur_base + AW'(out_idx))));
        if (out_idx % 2 == 0)
          check("R5 busy on first byte", 32'(in_ready), 32'd0);
        else
          check("R5 ready on second byte", 32'(in_ready), 32'(out_ready));
      end else begin
        check("R5 idle ready", 32'(in_ready), 32'd1);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_addr  = out_addr;
      if (out_valid && out_ready) out_idx++;
      if (in_valid && in_ready) in_idx++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    #1;
    check("R4 drained", 32'(out_valid), 32'd0);
    cur_base = AW'(cur_base + AW'(2 * nbytes));
  endtask

  initial begin
    rst_n     = 1'b0;
    base_load = 1'b0;
    base_addr = '0;
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R8 out_valid", 32'(out_valid), 32'd0);
    check("R8 in_ready", 32'(in_ready), 32'd1);
    check("R8 out_addr", 32'(out_addr), 32'd0);

    load_base(AW'(1020));
    run_pass(256, 1'b0);
    load_base(AW'(5));
    run_pass(256, 1'b1);
    load_base(AW'(1023));
    run_pass(3, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule